// File: doc/BRIEF.md
# Hierarchical Interrupt Flag and Vector Controller

This block gathers event pulses from a set of interrupt sources arranged in modules and records each event in a sticky per-source flag. A flag reaches the processor only if three gates are open: the source's own enable, the enable of the module the source belongs to, and one global enable. Every qualified flag feeds a single request line. All sources share one programmable vector register, and the processor jumps to the address it holds. An identification word shows which modules currently hold qualified requests. It also shows whether those requests come from the system group of modules or the peripheral group.

Software clears flags by writing ones to a clear port. An event that arrives in the same cycle as the clear keeps the flag set. Once the processor accepts the request through an acknowledge pulse, the request line is held low until a return pulse closes the service routine. After that return, a flag that was never cleared raises the request again. Sources can be marked asynchronous. Their events then pass through a two-stage synchronizer, and after a clear their request falls one cycle sooner than the request of a synchronous source.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Source i's event sets bit i of `flags_o`. The bit stays set until a clear write with bit i of `clr_mask_i` set. Clear writes whose mask bit i is zero leave it set.
- R2: `irq_o` is asserted for source i only when three enables are all set: source enable bit i, module enable bit i/SRC_PER_MOD, and the global enable. With any one of them zero, the flag still sets but `irq_o` stays low.
- R3: `vector_o` reads 0000h after reset until `vec_we_i` writes it. After a write it presents the written value from the next cycle onward.
- R4: `id_o[m]` is set while module m has a qualified flag. `id_o[NUM_MOD]` marks a qualified flag in a system module (index below NUM_SYS_MOD). `id_o[NUM_MOD+1]` marks one in a peripheral module.
- R5: A flag left set after service raises `irq_o` again in the cycle after the return pulse.
- R6: After a clear write at clock edge k, `irq_o` is still high after edge k. For an asynchronous source it is low after edge k+1. For a synchronous source it is low only after edge k+2.
- R7: When an event and a clear of the same flag meet in one cycle, the flag stays set.
- R8: An acknowledge while `irq_o` is high drives `irq_o` low from the next cycle until a return pulse. Flags and `id_o` are unaffected.
- R9: A synchronous source's flag is set after the first edge that samples its event. An asynchronous source (bit set in ASYNC_MASK) shows its flag two edges later.
- R10: After reset, `irq_o`, `flags_o` and `id_o` are zero and all enables are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | N | Event pulses, one per source |
| clr_we_i | input | 1 | Flag clear strobe |
| clr_mask_i | input | N | Write-one-to-clear mask |
| src_en_we_i | input | 1 | Source enable write strobe |
| src_en_wdata_i | input | N | Source enable value |
| mod_en_we_i | input | 1 | Module enable write strobe |
| mod_en_wdata_i | input | NUM_MOD | Module enable value |
| glob_en_we_i | input | 1 | Global enable write strobe |
| glob_en_wdata_i | input | 1 | Global enable value |
| vec_we_i | input | 1 | Vector write strobe |
| vec_wdata_i | input | VEC_W | Vector value |
| ack_i | input | 1 | Processor accepts the request |
| reti_i | input | 1 | Return from service routine |
| irq_o | output | 1 | Request to the processor |
| vector_o | output | VEC_W | Service routine address |
| id_o | output | NUM_MOD+2 | Module pending bits, system bit, peripheral bit |
| flags_o | output | N | Current flags |

## Verification
Each source in turn is pulsed alone with every gate open. This shows that the flag, the module bit and the system-or-peripheral bit all land on the right positions. Every source is then swept through all eight combinations of its three enables, which separates a gate that is missing from one wired to the wrong module. Clear writes are aimed at one asynchronous and one synchronous source and sampled edge by edge, which tells the two release delays apart. A collision of event and clear, and an acknowledge-return cycle with an uncleared flag, cover the set priority and the repeat of the request.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  typedef enum logic {SVC_IDLE = 1'b0, SVC_BUSY = 1'b1} svc_state_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int N = 12,
  parameter logic [N-1:0] ASYNC_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] evt_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (ASYNC_MASK[i]) begin : g_async
      logic [1:0] stg_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= 2'b00;
        else         stg_q <= {stg_q[0], evt_i[i]};
      end
      assign evt_o[i] = stg_q[1];
    end else begin : g_sync
      assign evt_o[i] = evt_i[i];
    end
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 12,
  parameter logic [N-1:0] ASYNC_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] hold_o
);
  logic [N-1:0] flag_q, flag_d, flag_dly_q;

  always_comb begin
    flag_d = flag_q;
    if (clr_we_i) flag_d = flag_d & ~clr_mask_i;
    flag_d = flag_d | set_i;          // a new event beats a clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q     <= '0;
      flag_dly_q <= '0;
    end else begin
      flag_q     <= flag_d;
      flag_dly_q <= flag_q;
    end
  end

  // synchronous sources keep their request one extra cycle after a clear
  for (genvar i = 0; i < N; i++) begin : g_hold
    if (ASYNC_MASK[i]) begin : g_a
      assign hold_o[i] = flag_q[i];
    end else begin : g_s
      assign hold_o[i] = flag_q[i] | flag_dly_q[i];
    end
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/irq_qualify.sv
module irq_qualify #(
  parameter int NUM_MOD     = 3,
  parameter int SRC_PER_MOD = 4,
  localparam int N = NUM_MOD * SRC_PER_MOD
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N-1:0]       hold_i,
  input  logic [N-1:0]       src_en_i,
  input  logic [NUM_MOD-1:0] mod_en_i,
  input  logic               glob_en_i,
  output logic [NUM_MOD-1:0] mod_pend_o
);
  logic [NUM_MOD-1:0] pend_d, pend_q;

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
    logic [SRC_PER_MOD-1:0] grp;
    assign grp       = hold_i[m*SRC_PER_MOD +: SRC_PER_MOD]
                     & src_en_i[m*SRC_PER_MOD +: SRC_PER_MOD];
    assign pend_d[m] = (|grp) & mod_en_i[m] & glob_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign mod_pend_o = pend_q;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_ctl_pkg::*;
#(
  parameter int NUM_MOD     = 3,
  parameter int SRC_PER_MOD = 4,
  parameter int NUM_SYS_MOD = 1,
  parameter int VEC_W       = 16,
  parameter logic [NUM_MOD*SRC_PER_MOD-1:0] ASYNC_MASK = 12'h0C3,
  localparam int N    = NUM_MOD * SRC_PER_MOD,
  localparam int ID_W = NUM_MOD + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N-1:0]       evt_i,
  input  logic               clr_we_i,
  input  logic [N-1:0]       clr_mask_i,
  input  logic               src_en_we_i,
  input  logic [N-1:0]       src_en_wdata_i,
  input  logic               mod_en_we_i,
  input  logic [NUM_MOD-1:0] mod_en_wdata_i,
  input  logic               glob_en_we_i,
  input  logic               glob_en_wdata_i,
  input  logic               vec_we_i,
  input  logic [VEC_W-1:0]   vec_wdata_i,
  input  logic               ack_i,
  input  logic               reti_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vector_o,
  output logic [ID_W-1:0]    id_o,
  output logic [N-1:0]       flags_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  logic [N-1:0]       evt_s, hold;
  logic [NUM_MOD-1:0] mod_pend;

  irq_sync #(.N(N), .ASYNC_MASK(ASYNC_MASK)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_n), .evt_i(evt_i), .evt_o(evt_s));

  irq_flag_bank #(.N(N), .ASYNC_MASK(ASYNC_MASK)) i_flags (
    .clk_i(clk_i), .rst_ni(rst_n), .set_i(evt_s), .clr_we_i(clr_we_i),
    .clr_mask_i(clr_mask_i), .flags_o(flags_o), .hold_o(hold));

  // enable and vector registers
  logic [N-1:0]       src_en_q, src_en_d;
  logic [NUM_MOD-1:0] mod_en_q, mod_en_d;
  logic               glob_en_q, glob_en_d;
  logic [VEC_W-1:0]   vec_q, vec_d;
  svc_state_t         svc_q, svc_d;

  irq_qualify #(.NUM_MOD(NUM_MOD), .SRC_PER_MOD(SRC_PER_MOD)) i_qual (
    .clk_i(clk_i), .rst_ni(rst_n), .hold_i(hold), .src_en_i(src_en_q),
    .mod_en_i(mod_en_q), .glob_en_i(glob_en_q), .mod_pend_o(mod_pend));

  always_comb begin
    src_en_d  = src_en_we_i  ? src_en_wdata_i  : src_en_q;
    mod_en_d  = mod_en_we_i  ? mod_en_wdata_i  : mod_en_q;
    glob_en_d = glob_en_we_i ? glob_en_wdata_i : glob_en_q;
    vec_d     = vec_we_i     ? vec_wdata_i     : vec_q;
    svc_d     = svc_q;
    if (reti_i)              svc_d = SVC_IDLE;
    else if (ack_i && irq_o) svc_d = SVC_BUSY;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      src_en_q  <= '0;
      mod_en_q  <= '0;
      glob_en_q <= 1'b0;
      vec_q     <= '0;
      svc_q     <= SVC_IDLE;
    end else begin
      src_en_q  <= src_en_d;
      mod_en_q  <= mod_en_d;
      glob_en_q <= glob_en_d;
      vec_q     <= vec_d;
      svc_q     <= svc_d;
    end
  end

  // identification: split modules into system and peripheral groups
  logic sys_any, per_any;
  always_comb begin
    sys_any = 1'b0;
    per_any = 1'b0;
    for (int m = 0; m < NUM_MOD; m++) begin
      if (m < NUM_SYS_MOD) sys_any = sys_any | mod_pend[m];
      else                 per_any = per_any | mod_pend[m];
    end
  end

  assign id_o     = {per_any, sys_any, mod_pend};
  assign irq_o    = (|mod_pend) && (svc_q == SVC_IDLE);
  assign vector_o = vec_q;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int N       = 12,
  parameter int NUM_MOD = 3,
  parameter int VEC_W   = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               irq_o,
  input logic               ack_i,
  input logic               reti_i,
  input logic               vec_we_i,
  input logic [VEC_W-1:0]   vector_o,
  input logic               clr_we_i,
  input logic [N-1:0]       flags_o,
  input logic [NUM_MOD+1:0] id_o,
  input logic               glob_en_i
);
  assert_flag_sticky_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  assert_global_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(glob_en_i));

  assert_vector_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_we_i |=> $stable(vector_o));

  assert_id_backs_irq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|id_o[NUM_MOD-1:0]));

  assert_service_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && ack_i && !reti_i) |=> !irq_o);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.N(N), .NUM_MOD(NUM_MOD), .VEC_W(VEC_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_o(irq_o), .ack_i(ack_i), .reti_i(reti_i),
  .vec_we_i(vec_we_i), .vector_o(vector_o), .clr_we_i(clr_we_i),
  .flags_o(flags_o), .id_o(id_o), .glob_en_i(glob_en_q));

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  localparam int NM = 3, SPM = 4, NSYS = 1, VW = 16;
  localparam int N = NM * SPM;
  localparam logic [N-1:0] AMASK = 12'h0C3;

  logic clk = 1'b0, rst_n;
  logic [N-1:0] evt, clr_mask, src_wd;
  logic clr_we, src_we, mod_we, glob_we, glob_wd, vec_we, ack, reti;
  logic [NM-1:0] mod_wd;
  logic [VW-1:0] vec_wd;
  logic irq;
  logic [VW-1:0] vec;
  logic [NM+1:0] id;
  logic [N-1:0] flags;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_vector_ctrl #(.NUM_MOD(NM), .SRC_PER_MOD(SPM), .NUM_SYS_MOD(NSYS),
                    .VEC_W(VW), .ASYNC_MASK(AMASK)) i_irq_vector_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .clr_we_i(clr_we),
    .clr_mask_i(clr_mask), .src_en_we_i(src_we), .src_en_wdata_i(src_wd),
    .mod_en_we_i(mod_we), .mod_en_wdata_i(mod_wd), .glob_en_we_i(glob_we),
    .glob_en_wdata_i(glob_wd), .vec_we_i(vec_we), .vec_wdata_i(vec_wd),
    .ack_i(ack), .reti_i(reti), .irq_o(irq), .vector_o(vec), .id_o(id),
    .flags_o(flags));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic set_en(logic [N-1:0] s, logic [NM-1:0] m, logic g);
    src_we = 1; src_wd = s; mod_we = 1; mod_wd = m; glob_we = 1; glob_wd = g;
    cyc(); src_we = 0; mod_we = 0; glob_we = 0;
  endtask

  task automatic pulse(int i);
    evt = '0; evt[i] = 1'b1; cyc(); evt = '0;
  endtask

  task automatic clear(logic [N-1:0] m);
    clr_we = 1; clr_mask = m; cyc(); clr_we = 0; clr_mask = '0;
  endtask

  function automatic logic [NM+1:0] exp_id(int i);
    logic [NM+1:0] r = '0;
    int m = i / SPM;
    r[m] = 1'b1;
    if (m < NSYS) r[NM] = 1'b1; else r[NM+1] = 1'b1;
    return r;
  endfunction

  initial begin
    evt = '0; clr_we = 0; clr_mask = '0; src_we = 0; src_wd = '0; mod_we = 0;
    mod_wd = '0; glob_we = 0; glob_wd = 0; vec_we = 0; vec_wd = '0; ack = 0; reti = 0;
    rst_n = 0;
    cyc(3); rst_n = 1; cyc(3);
    // R10 / R3 reset state
    check("R10 irq", irq, 0);
    check("R10 flags", flags, 0);
    check("R10 id", id, 0);
    check("R3 vector after reset", vec, 0);
    pulse(2); cyc(3);
    check("R10 enables off: irq", irq, 0);
    clear('1); cyc(3);

    // R1/R2/R4: every source alone, all gates open
    set_en('1, '1, 1'b1);
    for (int i = 0; i < N; i++) begin
      pulse(i); cyc(5);
      check("R1 flag set", flags, 32'(1) << i);
      check("R2 irq all enables", irq, 1);
      check("R4 id", id, exp_id(i));
      clear(~(N'(1) << i)); cyc(2);
      check("R1 other mask bits ignored", flags, 32'(1) << i);
      clear(N'(1) << i); cyc(4);
      check("R1 cleared", flags, 0);
      check("R2 irq gone", irq, 0);
    end

    // R2: enable sweep
    for (int i = 0; i < N; i++) begin
      for (int c = 0; c < 8; c++) begin
        logic [N-1:0] s = '1;
        logic [NM-1:0] m = '1;
        s[i] = c[0]; m[i/SPM] = c[1];
        set_en(s, m, c[2]);
        pulse(i); cyc(5);
        check("R2 enable combo irq", irq, (c == 7) ? 1 : 0);
        check("R2 flag sets regardless", flags[i], 1);
        clear('1); cyc(4);
      end
    end

    // R6: release timing (source 0 asynchronous, source 2 synchronous)
    set_en('1, '1, 1'b1);
    for (int k = 0; k < 2; k++) begin
      int s = (k == 0) ? 0 : 2;
      pulse(s); cyc(6);
      check("R6 irq before clear", irq, 1);
      clear(N'(1) << s);
      check("R6 irq after edge k", irq, 1);
      cyc();
      check("R6 irq after edge k+1", irq, AMASK[s] ? 0 : 1);
      cyc();
      check("R6 irq after edge k+2", irq, 0);
    end

    // R9: synchronizer latency
    pulse(2);
    check("R9 sync flag at first edge", flags[2], 1);
    clear('1); cyc(4);
    pulse(0);
    check("R9 async flag edge e", flags[0], 0);
    cyc();
    check("R9 async flag edge e+1", flags[0], 0);
    cyc();
    check("R9 async flag edge e+2", flags[0], 1);
    clear('1); cyc(4);

    // R7: set beats clear
    pulse(3); cyc();
    evt[3] = 1; clr_we = 1; clr_mask = N'(1) << 3; cyc();
    evt = '0; clr_we = 0; clr_mask = '0;
    check("R7 collision keeps flag", flags[3], 1);
    clear(N'(1) << 3);
    check("R7 plain clear", flags[3], 0);
    cyc(4);

    // R8 / R5: service masking and repeat
    pulse(4); cyc(4);
    check("R8 irq before ack", irq, 1);
    ack = 1; cyc(); ack = 0;
    check("R8 irq masked", irq, 0);
    check("R8 id kept", id, exp_id(4));
    cyc(3);
    check("R8 still masked", irq, 0);
    check("R8 flag kept", flags[4], 1);
    reti = 1; cyc(); reti = 0;
    check("R5 repeat after return", irq, 1);
    clear('1); cyc(4);

    // R3: vector programming
    vec_we = 1; vec_wd = 16'hA55A; cyc(); vec_we = 0;
    check("R3 vector written", vec, 16'hA55A);
    cyc(3);
    check("R3 vector held", vec, 16'hA55A);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule